// File: doc/BRIEF.md
# Multi-phase serial audio frame transmitter

This block serializes PCM words onto a single data line, bit by bit, paced by an externally supplied bit clock and framed by an external frame-sync signal. It runs on a fast system clock. The bit clock and frame sync are sampled as ordinary synchronous inputs, and the block acts on their edges. Each frame holds one or two phases, and each phase carries its own programmed count of words. Every word is 16 or 32 bits long and is sent most significant bit first.

A frame starts on the leading edge of the active frame-sync level. That edge is seen on the capture edge of the bit clock. The first data bit then leaves either on the very next launch edge or one bit clock later. The one-bit delay suits I2S-style and early-pulse DSP framing. The zero delay suits left-justified and late-pulse DSP framing. For stereo I2S or left-justified output, the frame is set up as two phases of one word each.

Words come from a valid/take stream, and one word is consumed per word slot. When no word is offered, the slot goes out as zeros. A master enable parks the line low and stops all consumption. This lets the feeding DMA be armed before serial output begins.

Top module: `pcm_frame_tx`

## Requirements
- R1: After reset, and while reset is held, `sd_o` is low and `in_take` and `underrun_o` are low.
- R2: With `cfg_wlen32`=1 each word is 32 bits, taken from `in_word[31:0]`. With `cfg_wlen32`=0 it is 16 bits, taken from `in_word[15:0]`. In both cases bits leave most significant first, one bit per launch edge.
- R3: Phase one carries `cfg_cnt1`+1 words, so the 4-bit field with value 15 gives 16 words.
- R4: With `cfg_dual`=1, phase one is followed without a gap by phase two, which carries `cfg_cnt2`+1 words.
- R5: With `cfg_delay1`=1, the first launch edge after frame start drives a low delay bit and data begins on the second launch edge. With `cfg_delay1`=0, data begins on the first launch edge.
- R6: With `cfg_bclk_inv`=0, data changes on falling bit-clock edges and frame sync is sampled on rising edges. With `cfg_bclk_inv`=1 both edges are swapped.
- R7: Frame sync is active high when `cfg_fs_low`=0 and active low when it is 1. A frame starts only when the sampled level goes from inactive to active, so holding it active does not restart the frame.
- R8: `in_take` pulses for one system cycle at the launch edge that starts each word slot while `in_valid` is high, and exactly one word is taken per slot.
- R9: A slot that starts with `in_valid` low pulses `underrun_o`, takes nothing and sends all zeros.
- R10: A frame-start edge that arrives in the middle of a frame abandons the current word and restarts at word one of phase one, honouring the data delay.
- R11: While `tx_en` is low, `sd_o` is low from the next cycle on, no word is taken, and frame syncs are ignored.
- R12: After the last word of a frame, `sd_o` stays low until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| cfg_wlen32 | input | 1 | 1: 32-bit words, 0: 16-bit words |
| cfg_dual | input | 1 | Enable the second phase |
| cfg_cnt1 | input | CNT_W | Phase one word count minus one |
| cfg_cnt2 | input | CNT_W | Phase two word count minus one |
| cfg_delay1 | input | 1 | One-bit data delay after frame sync |
| cfg_bclk_inv | input | 1 | Swap launch and capture bit-clock edges |
| cfg_fs_low | input | 1 | Frame sync active low |
| bclk | input | 1 | Bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, sampled by clk |
| in_valid | input | 1 | Word available |
| in_word | input | WORD_W | Word data, 16-bit words in the low half |
| in_take | output | 1 | Word consumed this cycle |
| underrun_o | output | 1 | Word slot began with no word available |
| sd_o | output | 1 | Serial data out |

## Verification
The assertions assume the following about the inputs:
- Each bit-clock level lasts at least two system cycles, so consecutive launch edges never fall in adjacent cycles.
- Configuration does not change while a word is being taken.
- `in_word` is stable in the cycle it is consumed.

The stimulus holds each bit-clock level for exactly two system cycles. It changes configuration only between frames, with the transmitter briefly disabled. It presents words as a pure function of a running index that advances only on `in_take`.

// File: rtl/pcm_frame_tx.sv
module pcm_frame_tx #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cfg_wlen32,
  input  logic              cfg_dual,
  input  logic [CNT_W-1:0]  cfg_cnt1,
  input  logic [CNT_W-1:0]  cfg_cnt2,
  input  logic              cfg_delay1,
  input  logic              cfg_bclk_inv,
  input  logic              cfg_fs_low,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_take,
  output logic              underrun_o,
  output logic              sd_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BIT_W  = $clog2(WORD_W);

  logic              bclk_q, fs_q, busy, pend, dly, phase;
  logic [CNT_W-1:0]  wcnt;
  logic [BIT_W-1:0]  bcnt;
  logic [WORD_W-1:0] sh;

  wire edge_seen  = bclk != bclk_q;
  wire launch     = edge_seen && (bclk == cfg_bclk_inv);
  wire capture    = edge_seen && (bclk != cfg_bclk_inv);
  wire fs_act     = fsync ^ cfg_fs_low;
  wire start      = capture && fs_act && !fs_q && tx_en;

  wire [BIT_W-1:0] last_bit = cfg_wlen32 ? BIT_W'(WORD_W - 1) : BIT_W'(HALF_W - 1);
  wire [CNT_W-1:0] ph_last  = phase ? cfg_cnt2 : cfg_cnt1;
  wire word_end   = busy && (bcnt == last_bit);
  wire more_words = wcnt != ph_last;
  wire next_phase = !phase && cfg_dual;
  wire begin_word = launch && ((pend && !dly) || (word_end && (more_words || next_phase)));

  wire [WORD_W-1:0] aligned = cfg_wlen32 ? in_word : {in_word[HALF_W-1:0], {HALF_W{1'b0}}};

  assign in_take    = tx_en && begin_word && in_valid;
  assign underrun_o = tx_en && begin_word && !in_valid;
  assign sd_o       = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      busy   <= 1'b0;
      pend   <= 1'b0;
      dly    <= 1'b0;
      phase  <= 1'b0;
      wcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
    end else begin
      bclk_q <= bclk;
      if (capture) fs_q <= fs_act;
      if (!tx_en) begin
        busy  <= 1'b0;
        pend  <= 1'b0;
        dly   <= 1'b0;
        phase <= 1'b0;
        wcnt  <= '0;
        bcnt  <= '0;
        sh    <= '0;
      end else if (start) begin
        pend  <= 1'b1;
        dly   <= cfg_delay1;
        busy  <= 1'b0;
        phase <= 1'b0;
        wcnt  <= '0;
        bcnt  <= '0;
      end else if (launch) begin
        if (begin_word) begin
          sh   <= in_valid ? aligned : '0;
          bcnt <= '0;
          busy <= 1'b1;
          pend <= 1'b0;
          if (!pend) begin
            if (more_words) begin
              wcnt <= wcnt + CNT_W'(1);
            end else begin
              phase <= 1'b1;
              wcnt  <= '0;
            end
          end
        end else if (pend) begin
          sh  <= '0;
          dly <= 1'b0;
        end else if (word_end) begin
          busy <= 1'b0;
          sh   <= '0;
        end else if (busy) begin
          sh   <= sh << 1;
          bcnt <= bcnt + BIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcm_frame_tx_chk.sv
module pcm_frame_tx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              cfg_wlen32,
  input logic [WORD_W-1:0] in_word,
  input logic              in_take,
  input logic              underrun_o,
  input logic              sd_o
);
  assert_take_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> !in_take);

  assert_take_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> sd_o == $past(cfg_wlen32 ? in_word[WORD_W-1] : in_word[WORD_W/2-1]));

  assert_under_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> !in_take);

  assert_under_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !sd_o);

  assert_disabled_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !sd_o);

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!in_take && !underrun_o));
endmodule

bind pcm_frame_tx pcm_frame_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_wlen32(cfg_wlen32),
  .in_word(in_word), .in_take(in_take), .underrun_o(underrun_o), .sd_o(sd_o)
);

// File: tb/sim_pcm_frame_tx.sv
`timescale 1ns/1ps
module sim_pcm_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
  logic cfg_wlen32 = 1'b0, cfg_dual = 1'b0, cfg_delay1 = 1'b0;
  logic cfg_bclk_inv = 1'b0, cfg_fs_low = 1'b0;
  logic [3:0] cfg_cnt1 = '0, cfg_cnt2 = '0;
  logic bclk = 1'b0, fsync = 1'b0, in_valid = 1'b1;
  logic [31:0] in_word;
  logic in_take, underrun_o, sd_o;
  int checks = 0, errors = 0, idx = 0, takes = 0, unders = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'h5A3C_96E1 ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  assign in_word = pat(idx);

  always @(posedge clk) begin
    if (in_take) begin idx <= idx + 1; takes <= takes + 1; end
    if (underrun_o) unders <= unders + 1;
  end

  pcm_frame_tx u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bitp(input bit fs_on, output logic v);
    bclk  = cfg_bclk_inv;
    fsync = fs_on ^ cfg_fs_low;
    repeat (2) @(negedge clk);
    bclk = !cfg_bclk_inv;
    repeat (2) @(negedge clk);
    v = sd_o;
  endtask

  function automatic logic expbit(input int j, wl, d, total, base);
    int b, w;
    if (j <= d) return 1'b0;
    b = j - 1 - d;
    w = b / wl;
    if (w >= total) return 1'b0;
    return pat(base + w)[wl - 1 - (b % wl)];
  endfunction

  task automatic setup(input int wl, d, dual, c1, c2, p);
    logic v;
    tx_en = 1'b0;
    cfg_wlen32 = (wl == 32); cfg_delay1 = d[0]; cfg_dual = dual[0];
    cfg_cnt1 = c1[3:0]; cfg_cnt2 = c2[3:0];
    cfg_bclk_inv = p[0]; cfg_fs_low = p[1];
    bitp(0, v);
    tx_en = 1'b1;
    bitp(0, v);
  endtask

  task automatic frame(input int wl, d, dual, c1, c2, p, fsw, input string tag);
    logic v;
    int total, nb, base, t0;
    string t;
    setup(wl, d, dual, c1, c2, p);
    total = c1 + 1 + (dual ? c2 + 1 : 0);
    nb = d + total * wl + 2;
    base = idx; t0 = takes;
    bitp(1, v);
    for (int j = 1; j <= nb; j++) begin
      bitp(j < fsw, v);
      if (j <= d) t = "R5";
      else if (j > d + total * wl) t = "R12";
      else t = tag;
      chk(t, v, expbit(j, wl, d, total, base));
    end
    chk("R8 takes", takes - t0, total);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v;
    int base, t0, u0c;
    repeat (3) @(negedge clk);
    chk("R1 sd", sd_o, 0);
    chk("R1 take", in_take, 0);
    chk("R1 under", underrun_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sd after", sd_o, 0);

    for (int p = 0; p < 4; p++)
      for (int wsel = 0; wsel < 2; wsel++)
        for (int d = 0; d < 2; d++) begin
          automatic int wl = wsel ? 32 : 16;
          automatic string tg = (p == 0) ? "R2" : (p[0] ? "R6" : "R7");
          frame(wl, d, 0, 0, 0, p, 1, tg);
          frame(wl, d, 0, 1, 0, p, 1, (p == 0) ? "R3" : tg);
          frame(wl, d, 1, 0, 0, p, 1, (p == 0) ? "R4" : tg);
          frame(wl, d, 1, 2, 1, p, 1, (p == 0) ? "R4" : tg);
          if (wl == 16) frame(wl, d, 0, 15, 0, p, 1, (p == 0) ? "R3" : tg);
        end

    // held frame sync must not restart
    frame(16, 1, 1, 1, 1, 0, 3, "R7");
    frame(32, 0, 0, 2, 0, 2, 5, "R7");

    // underrun
    setup(16, 0, 1, 1, 0, 0);
    in_valid = 1'b0;
    t0 = takes; u0c = unders;
    bitp(1, v);
    for (int j = 1; j <= 3 * 16 + 2; j++) begin
      bitp(0, v);
      chk("R9 bit", v, 0);
    end
    chk("R9 takes", takes - t0, 0);
    chk("R9 underruns", unders - u0c, 3);
    in_valid = 1'b1;

    // mid-frame restart
    for (int d = 0; d < 2; d++) begin
      setup(16, d, 1, 1, 0, 0);
      base = idx; t0 = takes;
      bitp(1, v);
      for (int j = 1; j <= 5; j++) bitp(0, v);
      bitp(1, v);
      for (int j = 1; j <= d + 3 * 16 + 2; j++) begin
        bitp(0, v);
        chk((j <= d) ? "R5" : "R10", v, expbit(j, 16, d, 3, base + 1));
      end
      chk("R10 takes", takes - t0, 4);
    end

    // disabled: frame syncs ignored
    setup(16, 0, 0, 1, 0, 0);
    tx_en = 1'b0;
    t0 = takes; u0c = unders;
    bitp(1, v);
    for (int j = 1; j <= 40; j++) begin
      bitp(0, v);
      chk("R11 idle", v, 0);
    end
    chk("R11 takes", takes - t0, 0);
    chk("R11 underruns", unders - u0c, 0);

    // disable mid-frame, then a clean frame afterwards
    setup(32, 0, 0, 3, 0, 0);
    base = idx;
    bitp(1, v);
    for (int j = 1; j <= 6; j++) begin
      bitp(0, v);
      chk("R2 pre-disable", v, expbit(j, 32, 0, 4, base));
    end
    t0 = takes;
    tx_en = 1'b0;
    @(negedge clk);
    chk("R11 forced low", sd_o, 0);
    for (int j = 1; j <= 40; j++) begin
      bitp(0, v);
      chk("R11 stays low", v, 0);
    end
    chk("R11 no take", takes - t0, 0);
    frame(32, 1, 0, 0, 0, 0, 1, "R11");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule